// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader

This block copies a boot image from a serial EEPROM into on-chip memory. The image is a chain of blocks. Each block has a fixed 14-byte header, then a payload, then a 2-byte payload checksum. The loader reads the EEPROM one byte at a time through an external I2C master, using a request/valid handshake. It writes payload bytes to a byte-wide memory port and follows the chain until it reaches a terminating block or finds an error.

The EEPROM address space is 19 bits wide. The top three address bits go into the low bits of the 7-bit I2C device address, and the low 16 bits form the word address. The header fields are, in order:

| Bytes | Field |
|-------|-------|
| 1 | Control byte |
| 3 | Payload length |
| 4 | Link to the next block |
| 4 | Destination address |
| 2 | Header checksum |

All multi-byte fields are stored most significant byte first.

The control byte carries three fields. Bit 7 enables checksum checking. Bit 6 is reserved. Bits 5:0 hold the destination chip ID. A block whose ID matches neither the local ID nor the broadcast value is still read from the EEPROM, so the chain can continue, but none of its bytes are written to memory.

Top module: `eeprom_boot_loader`

## Requirements
- R1: Every read request drives `rd_dev_o` = {4'b1010, eeprom_addr[18:16]} and `rd_word_o` = eeprom_addr[15:0]. The request holds `rd_req_o` high, and it is consumed in the cycle `rd_valid_i` is high.
- R2: Payload byte k of an accepted block is written with `mem_addr_o` = destination + k and with its data on `mem_data_o`, one `mem_we_o` pulse per byte, in order. Length and address fields are read most significant byte first.
- R3: A block is accepted when control bits 5:0 equal `chip_id_i` or equal 6'h3F. Otherwise its payload is read but `mem_we_o` never pulses for it.
- R4: A link value of 0x00000000 makes the next header start at the byte right after the current payload checksum.
- R5: Any other link value, except all ones, makes the next header start at its low 19 bits.
- R6: A link value of 0xFFFFFFFF ends loading after that block's payload checksum. `done_o` goes high, `busy_o` goes low, and no further reads are requested.
- R7: When control bit 7 is set, the header checksum is compared with the 16-bit sum of the 12 header bytes. A mismatch stops loading with `err_code_o` = 1. When bit 7 is clear, a mismatch has no effect.
- R8: When control bit 7 is set, the payload checksum is compared with the 16-bit sum of the payload bytes. A mismatch stops loading with `err_code_o` = 2, after the payload has been written.
- R9: A control byte with bit 6 set stops loading with `err_code_o` = 3 before its header checksum is read, and no write is issued for that block.
- R10: A block with a zero payload length issues no writes. Its payload checksum, compared against 0, is still read.
- R11: After reset, all outputs are low and `err_code_o` is 0. A `start_i` pulse while idle, done or in error begins at EEPROM address 0 and clears `done_o` and `error_o`.
- R12: `done_o` and `error_o` are never high together. Each stays high until the next `start_i`, and `err_code_o` is non-zero exactly while `error_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin loading from EEPROM address 0 |
| chip_id_i | input | 6 | Local chip identifier |
| rd_req_o | output | 1 | Byte read request to the I2C master |
| rd_dev_o | output | 7 | I2C device address of the request |
| rd_word_o | output | 16 | EEPROM word address of the request |
| rd_valid_i | input | 1 | Read data valid; consumes the request |
| rd_data_i | input | 8 | Read data byte |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_data_o | output | 8 | Memory write data |
| busy_o | output | 1 | Loading in progress |
| done_o | output | 1 | Chain completed |
| error_o | output | 1 | Loading stopped on an error |
| err_code_o | output | 2 | 1 header checksum, 2 payload checksum, 3 format |

## Verification
The bench builds a chain of blocks that exercises every kind of link:

- The first link is sequential.
- The second link jumps above 64 KB, so the device address must carry a non-zero high part. A loader that drops those bits reads from the wrong location and misses the expected writes.
- A foreign-ID block with deliberately wrong checksums and checking disabled sits in the middle. A design that checks checksums regardless of bit 7 stops with an error, and one that ignores the ID writes unexpected bytes.
- A zero-length block ends the chain. A loader that mishandles it underflows its length counter and keeps reading.

Separate images then corrupt the header checksum, corrupt the payload checksum and set the reserved bit. Each must end with the distinct error code and the exact set of writes.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CHK, ST_HCS, ST_PAY, ST_PCS, ST_DONE, ST_ERR
  } ebl_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_HDR_CSUM = 2'd1,
    ERR_PAY_CSUM = 2'd2,
    ERR_FORMAT   = 2'd3
  } ebl_err_e;

  localparam int unsigned CTRL_BYTES = 1;
  localparam int unsigned LEN_BYTES  = 3;
  localparam int unsigned LINK_BYTES = 4;
  localparam int unsigned DEST_BYTES = 4;
  localparam int unsigned HDR_BYTES  = CTRL_BYTES + LEN_BYTES + LINK_BYTES + DEST_BYTES;
  localparam int unsigned CSUM_W     = 16;
endpackage

// File: rtl/ebl_addr_map.sv
module ebl_addr_map #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned WORD_W = 16,
  parameter logic [3:0]  PREFIX = 4'b1010
) (
  input  logic [ADDR_W-1:0] ee_addr_i,
  output logic [6:0]        dev_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned HI_W = ADDR_W - WORD_W;

  assign word_o = ee_addr_i[WORD_W-1:0];
  assign dev_o  = {PREFIX, ee_addr_i[ADDR_W-1 -: HI_W]};
endmodule

// File: rtl/ebl_csum.sv
module ebl_csum #(
  parameter int unsigned SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [7:0]       byte_i,
  output logic [SUM_W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_o + SUM_W'(byte_i);
  end
endmodule

// File: rtl/ebl_hdr_shift.sv
module ebl_hdr_shift
  import ebl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        shift_i,
  input  logic [7:0]  byte_i,
  output logic [7:0]  ctrl_o,
  output logic [LEN_BYTES*8-1:0]  len_o,
  output logic [LINK_BYTES*8-1:0] link_o,
  output logic [DEST_BYTES*8-1:0] dest_o
);
  localparam int unsigned HW = HDR_BYTES * 8;
  localparam int unsigned DEST_LO = 0;
  localparam int unsigned LINK_LO = DEST_LO + DEST_BYTES * 8;
  localparam int unsigned LEN_LO  = LINK_LO + LINK_BYTES * 8;
  localparam int unsigned CTRL_LO = LEN_LO + LEN_BYTES * 8;

  logic [HW-1:0] sh_q;

  // MSB-first fields: each new byte enters at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[HW-9:0], byte_i};
  end

  assign ctrl_o = sh_q[CTRL_LO +: CTRL_BYTES*8];
  assign len_o  = sh_q[LEN_LO  +: LEN_BYTES*8];
  assign link_o = sh_q[LINK_LO +: LINK_BYTES*8];
  assign dest_o = sh_q[DEST_LO +: DEST_BYTES*8];
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
  import ebl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ID_W       = 6,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] chip_id_i,
  output logic            rd_req_o,
  output logic [6:0]      rd_dev_o,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic            rd_valid_i,
  input  logic [7:0]      rd_data_i,
  output logic            mem_we_o,
  output logic [31:0]     mem_addr_o,
  output logic [7:0]      mem_data_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            error_o,
  output logic [1:0]      err_code_o
);
  localparam int unsigned LEN_W  = LEN_BYTES * 8;
  localparam int unsigned LINK_W = LINK_BYTES * 8;
  localparam int unsigned DEST_W = DEST_BYTES * 8;
  localparam int unsigned IDX_W  = $clog2(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);
  localparam logic [ID_W-1:0]  BCAST_ID = '1;
  localparam int unsigned CSE_BIT = 7;
  localparam int unsigned RSV_BIT = 6;

  ebl_state_e state_q;
  ebl_err_e   err_q;
  logic [ADDR_W-1:0] ee_addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  off_q;
  logic [7:0]        cs_hi_q;

  logic [7:0]        ctrl;
  logic [LEN_W-1:0]  blk_len;
  logic [LINK_W-1:0] blk_link;
  logic [DEST_W-1:0] blk_dest;
  logic [CSUM_W-1:0] sum;

  logic take, in_read, cs_clr, cs_add, hdr_shift;
  logic id_hit, cs_bad, link_end, link_seq;

  assign in_read = (state_q == ST_HDR) || (state_q == ST_HCS) ||
                   (state_q == ST_PAY) || (state_q == ST_PCS);
  assign take    = in_read && rd_valid_i;

  ebl_addr_map #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PREFIX(DEV_PREFIX)
  ) u_map (
    .ee_addr_i(ee_addr_q), .dev_o(rd_dev_o), .word_o(rd_word_o)
  );

  assign hdr_shift = take && (state_q == ST_HDR);
  ebl_hdr_shift u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(hdr_shift), .byte_i(rd_data_i),
    .ctrl_o(ctrl), .len_o(blk_len), .link_o(blk_link), .dest_o(blk_dest)
  );

  assign cs_add = take && ((state_q == ST_HDR) || (state_q == ST_PAY));
  ebl_csum #(.SUM_W(CSUM_W)) u_csum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cs_clr), .add_i(cs_add),
    .byte_i(rd_data_i), .sum_o(sum)
  );

  assign id_hit   = (ctrl[ID_W-1:0] == chip_id_i) || (ctrl[ID_W-1:0] == BCAST_ID);
  assign cs_bad   = ctrl[CSE_BIT] && ({cs_hi_q, rd_data_i} != sum);
  assign link_end = &blk_link;
  assign link_seq = ~|blk_link;

  logic can_start;
  assign can_start = start_i &&
                     ((state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR));

  // clear on (re)start and when leaving either checksum field
  assign cs_clr = can_start ||
                  (take && idx_q[0] && ((state_q == ST_HCS) || (state_q == ST_PCS)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_NONE;
      ee_addr_q  <= START_ADDR;
      idx_q      <= '0;
      off_q      <= '0;
      cs_hi_q    <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (take) ee_addr_q <= ee_addr_q + 1'b1;

      if (can_start) begin
        state_q   <= ST_HDR;
        err_q     <= ERR_NONE;
        ee_addr_q <= START_ADDR;
        idx_q     <= '0;
      end else begin
        unique case (state_q)
          ST_HDR: if (take) begin
            if (idx_q == IDX_LAST) begin
              idx_q   <= '0;
              state_q <= ST_CHK;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_CHK: begin
            if (ctrl[RSV_BIT]) begin
              err_q   <= ERR_FORMAT;
              state_q <= ST_ERR;
            end else begin
              state_q <= ST_HCS;
            end
          end
          ST_HCS: if (take) begin
            if (!idx_q[0]) begin
              cs_hi_q <= rd_data_i;
              idx_q   <= 1;
            end else begin
              idx_q <= '0;
              off_q <= '0;
              if (cs_bad) begin
                err_q   <= ERR_HDR_CSUM;
                state_q <= ST_ERR;
              end else if (blk_len == '0) begin
                state_q <= ST_PCS;
              end else begin
                state_q <= ST_PAY;
              end
            end
          end
          ST_PAY: if (take) begin
            if (id_hit) begin
              mem_we_o   <= 1'b1;
              mem_addr_o <= blk_dest + DEST_W'(off_q);
              mem_data_o <= rd_data_i;
            end
            if (off_q == blk_len - 1'b1) state_q <= ST_PCS;
            else                         off_q   <= off_q + 1'b1;
          end
          ST_PCS: if (take) begin
            if (!idx_q[0]) begin
              cs_hi_q <= rd_data_i;
              idx_q   <= 1;
            end else begin
              idx_q <= '0;
              if (cs_bad) begin
                err_q   <= ERR_PAY_CSUM;
                state_q <= ST_ERR;
              end else if (link_end) begin
                state_q <= ST_DONE;
              end else begin
                state_q <= ST_HDR;
                if (!link_seq) ee_addr_q <= blk_link[ADDR_W-1:0];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_req_o   = in_read;
  assign busy_o     = in_read || (state_q == ST_CHK);
  assign done_o     = (state_q == ST_DONE);
  assign error_o    = (state_q == ST_ERR);
  assign err_code_o = err_q;
endmodule

// File: rtl/ebl_checker.sv
module ebl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rd_req_o,
  input logic [6:0] rd_dev_o,
  input logic       mem_we_o,
  input logic       done_o,
  input logic       error_o,
  input logic [1:0] err_code_o
);
  assert_dev_prefix_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_dev_o[6:3] == 4'b1010));

  assert_no_read_when_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);

  assert_no_write_after_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) && $past(done_o || error_o) |-> !mem_we_o);

  assert_status_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  assert_error_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> (error_o && $stable(err_code_o)));

  assert_done_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_code_matches_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o == (err_code_o != 2'd0));
endmodule

bind eeprom_boot_loader ebl_checker u_ebl_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_dev_o(rd_dev_o), .mem_we_o(mem_we_o), .done_o(done_o),
  .error_o(error_o), .err_code_o(err_code_o)
);

// File: tb/eeprom_boot_loader_bench.sv
module eeprom_boot_loader_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [5:0] MY_ID = 6'd5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] chip_id_i = MY_ID;
  logic rd_req_o, rd_valid_i = 1'b0;
  logic [6:0] rd_dev_o;
  logic [15:0] rd_word_o;
  logic [7:0] rd_data_i = '0;
  logic mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0] mem_data_o;
  logic busy_o, done_o, error_o;
  logic [1:0] err_code_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] ee [int unsigned];
  logic [39:0] exp_q [$];
  int reads = 0;
  bit bad_prefix = 0;
  bit saw_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_boot_loader u_eeprom_boot_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chip_id_i(chip_id_i),
    .rd_req_o(rd_req_o), .rd_dev_o(rd_dev_o), .rd_word_o(rd_word_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .err_code_o(err_code_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model: answer a pending request every other cycle
  initial forever begin
    @(negedge clk);
    if (rd_valid_i) rd_valid_i = 1'b0;
    else if (rd_req_o) begin
      int unsigned a;
      a = {13'd0, rd_dev_o[2:0], rd_word_o};
      if (rd_dev_o[6:3] != 4'b1010) bad_prefix = 1;
      if (rd_dev_o == 7'h55 && rd_word_o == 16'h1234) saw_hi = 1;
      rd_data_i = ee.exists(a) ? ee[a] : 8'hFF;
      rd_valid_i = 1'b1;
      reads++;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (mem_we_o) begin
      if (exp_q.size() == 0)
        check(0, "R3", "unexpected write addr", {32'd0, mem_addr_o}, 64'd0);
      else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        check({mem_addr_o, mem_data_o} == e, "R2", "write addr/data",
              {24'd0, mem_addr_o, mem_data_o}, {24'd0, e});
      end
    end
  end

  task automatic put(input int unsigned a, input logic [7:0] b);
    ee[a & 32'h7FFFF] = b;
  endtask

  task automatic build_block(input int unsigned base, input logic [7:0] ctrl,
      input int unsigned len, input logic [31:0] link, input logic [31:0] dest,
      input logic [7:0] seed, input bit bad_h, input bit bad_p, input bit wr);
    logic [7:0] h [12];
    logic [15:0] s;
    h[0] = ctrl;
    h[1] = len[23:16]; h[2] = len[15:8]; h[3] = len[7:0];
    h[4] = link[31:24]; h[5] = link[23:16]; h[6] = link[15:8]; h[7] = link[7:0];
    h[8] = dest[31:24]; h[9] = dest[23:16]; h[10] = dest[15:8]; h[11] = dest[7:0];
    s = '0;
    for (int i = 0; i < 12; i++) begin
      put(base + i, h[i]);
      s += 16'(h[i]);
    end
    s += 16'(bad_h);
    put(base + 12, s[15:8]); put(base + 13, s[7:0]);
    s = '0;
    for (int k = 0; k < len; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 7);
      put(base + 14 + k, d);
      s += 16'(d);
      if (wr) exp_q.push_back({dest + k, d});
    end
    s += 16'(bad_p);
    put(base + 14 + len, s[15:8]); put(base + 15 + len, s[7:0]);
  endtask

  task automatic run_image();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (done_o || error_o) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!rd_req_o && !mem_we_o && !busy_o && !done_o && !error_o && err_code_o == 0,
          "R11", "reset outputs", {rd_req_o, mem_we_o, busy_o, done_o, error_o, err_code_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !rd_req_o, "R11", "idle after reset", busy_o, 0);

    // chain: seq link, high jump, foreign block, zero-length end
    ee.delete();
    build_block(0,        8'h85, 4, 32'h0,        32'h1000, 8'h11, 0, 0, 1);
    build_block(20,       8'hBF, 3, 32'h0005_1234, 32'h2000, 8'h40, 0, 0, 1);
    build_block(32'h51234, 8'h09, 2, 32'h40,       32'h3000, 8'h70, 1, 1, 0);
    build_block(64,       8'h85, 0, 32'hFFFF_FFFF, 32'h4000, 8'h00, 0, 0, 1);
    run_image();
    check(done_o && !error_o, "R6", "chain done", {done_o, error_o}, 2'b10);
    check(!busy_o, "R6", "busy low at end", busy_o, 0);
    check(exp_q.size() == 0, "R4", "sequential block written", exp_q.size(), 0);
    check(saw_hi, "R5", "jump to 0x51234 read", saw_hi, 1);
    check(!bad_prefix, "R1", "device prefix", bad_prefix, 0);
    check(err_code_o == 0, "R7", "disabled checksum ignored", err_code_o, 0);
    begin
      int r0;
      r0 = reads;
      repeat (10) @(negedge clk);
      check(reads == r0 && done_o, "R10", "zero-length end stays done", reads - r0, 0);
    end

    // R7 header checksum error
    ee.delete(); exp_q.delete();
    build_block(0, 8'h85, 3, 32'hFFFF_FFFF, 32'h5000, 8'h22, 1, 0, 0);
    run_image();
    check(error_o && err_code_o == 1, "R7", "header csum code", err_code_o, 1);
    check(!done_o, "R12", "done low on error", done_o, 0);

    // R8 payload checksum error after writes
    ee.delete(); exp_q.delete();
    build_block(0, 8'hBF, 3, 32'hFFFF_FFFF, 32'h6000, 8'h33, 0, 1, 1);
    run_image();
    check(error_o && err_code_o == 2, "R8", "payload csum code", err_code_o, 2);
    check(exp_q.size() == 0, "R8", "payload written before error", exp_q.size(), 0);

    // R9 reserved bit
    ee.delete(); exp_q.delete();
    build_block(0, 8'h45, 3, 32'hFFFF_FFFF, 32'h7000, 8'h44, 0, 0, 0);
    run_image();
    check(error_o && err_code_o == 3, "R9", "format code", err_code_o, 3);
    repeat (20) @(negedge clk);
    check(error_o && err_code_o == 3, "R12", "error sticky", err_code_o, 3);

    // R11 restart clears error, R3 foreign-only chain writes nothing
    ee.delete(); exp_q.delete();
    build_block(0, 8'h8A, 2, 32'hFFFF_FFFF, 32'h8000, 8'h55, 0, 0, 0);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(!error_o && busy_o, "R11", "start clears error", {error_o, busy_o}, 2'b01);
    for (int c = 0; c < 2000; c++) begin
      if (done_o || error_o) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(done_o && err_code_o == 0, "R3", "foreign block done", {done_o, err_code_o}, 3'b100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule